// File: doc/BRIEF.md
# SD Bus Power Control Sequencer

This block sequences the card-side signal lines of an SD/MMC host through its power states. Software writes a 2-bit power-control code over a simple write strobe and can read the code back at any time. The block drives an output enable and an output value for the card clock line, the command line and each data line. It also tells the rest of the host when normal bus operation may begin.

Four states exist. The hardware-reset state and an explicit power-off both read back as 00, but they leave the pads in different conditions. Power-cycle drives every line low. Power-on gates the card clock from a one-cycle tick input, one tick per card clock period. It keeps the host disabled for a fixed number of card clocks and then hands the pads to the protocol logic. Once power-on is reached, the code is locked until reset.

Top module: `sd_pwr_seq`

## Requirements
- R1: While reset (synchronous, active low) is asserted and after its release, the readback is 00, host_en and pad_sel are 0, and the card clock line is driven low (oe=1, out=0). The command and data lines are undriven (oe=0, out=0).
- R2: A write of code 00 while unlocked selects power-off. The readback is 00, host_en stays 0, and the clock, command and all data lines have oe=1 and out=1.
- R3: A write of code 10 while unlocked selects power-cycle. The readback is 10, host_en stays 0, and the clock, command and all data lines have oe=1 and out=0.
- R4: A write of code 11 while unlocked selects power-on. The readback is 11, and all lines have oe=1 with command and data out=1. The clock line's out is 1 in the cycle after a tick and 0 otherwise.
- R5: In power-on, host_en and pad_sel stay 0 through the first 73 ticks. Both go to 1 in the cycle after the 74th tick and stay at 1 until reset. Ticks are counted only once power-on is already held.
- R6: While the readback is 11, every write (any code) is ignored, and the readback and pad states are unchanged.
- R7: A write of code 01 is reserved and ignored: the readback and pad states are kept.
- R8: A write of the code already held leaves the readback and pad states unchanged.
- R9: Pad outputs are registered. A state change takes effect on the clock edge that takes the write. After reset, re-entering power-on restarts the 74-tick count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe for the power code |
| wr_data | input | 2 | Power code to write |
| rd_data | output | 2 | Power code readback |
| ck_tick | input | 1 | One-cycle pulse per card clock period |
| clk_oe | output | 1 | Card clock line output enable |
| clk_out | output | 1 | Card clock line value |
| cmd_oe | output | 1 | Command line output enable |
| cmd_out | output | 1 | Command line value |
| dat_oe | output | 8 | Data line output enables |
| dat_out | output | 8 | Data line values |
| host_en | output | 1 | Normal bus operation may begin |
| pad_sel | output | 1 | Pads handed to protocol logic |

## Verification
The assertions assume that ck_tick is a clean single-cycle pulse and that tick counting only matters once the readback shows 11. The bench drives ticks as isolated one-cycle pulses with gaps of one to three cycles and never raises a tick in the same cycle as a write. It sweeps every code from every unlocked state. It then performs all writes while locked, so the checker's tick counter and the design's view of power-on stay aligned.

// File: rtl/sd_pwr_seq.sv
module sd_pwr_seq #(
  parameter int START_CLKS = 74,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_data,
  output logic [1:0]        rd_data,
  input  logic              ck_tick,
  output logic              clk_oe,
  output logic              clk_out,
  output logic              cmd_oe,
  output logic              cmd_out,
  output logic [DATA_W-1:0] dat_oe,
  output logic [DATA_W-1:0] dat_out,
  output logic              host_en,
  output logic              pad_sel
);
  localparam int CW = $clog2(START_CLKS + 1);
  localparam logic [CW-1:0] LAST = CW'(START_CLKS - 1);

  typedef enum logic [1:0] {S_RST, S_OFF, S_CYC, S_ON} st_t;
  st_t st, nx;
  logic [CW-1:0] cnt;
  logic en_q;

  always_comb begin
    nx = st;
    if (wr_en && st != S_ON)
      case (wr_data)
        2'b00:   nx = S_OFF;
        2'b10:   nx = S_CYC;
        2'b11:   nx = S_ON;
        default: nx = st;
      endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st <= S_RST;
    else        st <= nx;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || st != S_ON) begin
      cnt  <= '0;
      en_q <= 1'b0;
    end else if (ck_tick && !en_q) begin
      cnt <= cnt + 1'b1;
      if (cnt == LAST) en_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      clk_oe  <= 1'b1;
      clk_out <= 1'b0;
      cmd_oe  <= 1'b0;
      cmd_out <= 1'b0;
      dat_oe  <= '0;
      dat_out <= '0;
    end else begin
      case (nx)
        S_RST: begin
          clk_oe <= 1'b1; clk_out <= 1'b0;
          cmd_oe <= 1'b0; cmd_out <= 1'b0;
          dat_oe <= '0;   dat_out <= '0;
        end
        S_OFF: begin
          clk_oe <= 1'b1; clk_out <= 1'b1;
          cmd_oe <= 1'b1; cmd_out <= 1'b1;
          dat_oe <= '1;   dat_out <= '1;
        end
        S_CYC: begin
          clk_oe <= 1'b1; clk_out <= 1'b0;
          cmd_oe <= 1'b1; cmd_out <= 1'b0;
          dat_oe <= '1;   dat_out <= '0;
        end
        default: begin
          clk_oe <= 1'b1; clk_out <= ck_tick && (st == S_ON);
          cmd_oe <= 1'b1; cmd_out <= 1'b1;
          dat_oe <= '1;   dat_out <= '1;
        end
      endcase
    end
  end

  assign rd_data = (st == S_ON) ? 2'b11 : (st == S_CYC) ? 2'b10 : 2'b00;
  assign host_en = en_q;
  assign pad_sel = en_q;
endmodule

// File: rtl/sd_pwr_seq_chk.sv
module sd_pwr_seq_chk #(
  parameter int START_CLKS = 74,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [1:0]        wr_data,
  input logic              ck_tick,
  input logic [1:0]        rd_data,
  input logic              host_en,
  input logic              pad_sel,
  input logic              cmd_out,
  input logic [DATA_W-1:0] dat_out
);
  logic [15:0] tcnt;
  always_ff @(posedge clk) begin
    if (!rst_n || rd_data != 2'b11) tcnt <= '0;
    else if (ck_tick && !host_en)   tcnt <= tcnt + 16'd1;
  end

  p_sel_match_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pad_sel == host_en);
  p_en_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    host_en |=> host_en);
  p_en_only_on_r5: assert property (@(posedge clk) disable iff (!rst_n)
    host_en |-> rd_data == 2'b11);
  p_start_count_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(host_en) |-> tcnt == 16'(START_CLKS));
  p_lock_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data == 2'b11 |=> rd_data == 2'b11);
  p_reserved_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data == 2'b01) |=> $stable(rd_data));
  p_cycle_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data == 2'b10 |-> (cmd_out == 1'b0 && dat_out == '0));
endmodule

bind sd_pwr_seq sd_pwr_seq_chk #(.START_CLKS(START_CLKS), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
  .ck_tick(ck_tick), .rd_data(rd_data), .host_en(host_en),
  .pad_sel(pad_sel), .cmd_out(cmd_out), .dat_out(dat_out)
);

// File: tb/sd_pwr_seq_test.sv
module sd_pwr_seq_test;
  logic clk = 0, rst_n = 0, wr_en = 0, ck_tick = 0;
  logic [1:0] wr_data = 0;
  logic [1:0] rd_data;
  logic clk_oe, clk_out, cmd_oe, cmd_out, host_en, pad_sel;
  logic [7:0] dat_oe, dat_out;
  int checks = 0, errors = 0;
  int m = 0;

  always #2 clk = ~clk;

  sd_pwr_seq uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .ck_tick(ck_tick), .clk_oe(clk_oe), .clk_out(clk_out), .cmd_oe(cmd_oe),
    .cmd_out(cmd_out), .dat_oe(dat_oe), .dat_out(dat_out),
    .host_en(host_en), .pad_sel(pad_sel)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] pads();
    return {8'h0, clk_oe, clk_out, cmd_oe, cmd_out, rd_data, 2'b0, dat_oe, dat_out};
  endfunction

  function automatic logic [31:0] exp_pads(input int s, input bit tk);
    logic oe, v, ck, co; logic [1:0] rd;
    case (s)
      0: begin oe = 0; v = 0; ck = 0; co = 1; rd = 2'b00; end
      1: begin oe = 1; v = 1; ck = 1; co = 1; rd = 2'b00; end
      2: begin oe = 1; v = 0; ck = 0; co = 1; rd = 2'b10; end
      default: begin oe = 1; v = 1; ck = tk; co = 1; rd = 2'b11; end
    endcase
    return {8'h0, co, ck, oe, v, rd, 2'b0, {8{oe}}, {8{v}}};
  endfunction

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    @(negedge clk);
    chk(pads() == exp_pads(0, 0) && !host_en && !pad_sel, "R1 during reset", pads(), exp_pads(0, 0));
    @(negedge clk); rst_n = 1;
    @(negedge clk);
    m = 0;
    chk(pads() == exp_pads(0, 0) && !host_en && !pad_sel, "R1 after reset", pads(), exp_pads(0, 0));
  endtask

  task automatic wr(input logic [1:0] v, input string req);
    int nm;
    @(negedge clk); wr_en = 1; wr_data = v;
    @(negedge clk); wr_en = 0;
    nm = m;
    if (m != 3) begin
      if (v == 2'b00) nm = 1;
      else if (v == 2'b10) nm = 2;
      else if (v == 2'b11) nm = 3;
    end
    m = nm;
    chk(pads() == exp_pads(m, 0), req, pads(), exp_pads(m, 0));
  endtask

  task automatic tick(input int gap, input bit exp_en, input string req);
    @(negedge clk); ck_tick = 1;
    @(negedge clk); ck_tick = 0;
    chk(pads() == exp_pads(m, m == 3) && host_en == exp_en && pad_sel == exp_en,
        req, {pads()[31:1], host_en}, {exp_pads(m, m == 3)[31:1], exp_en});
    for (int g = 1; g < gap; g++) @(negedge clk);
  endtask

  task automatic power_on_run(input int gap);
    wr(2'b11, "R4 enter power-on");
    chk(!host_en, "R5 disabled on entry", host_en, 0);
    for (int i = 1; i <= 74; i++) tick(gap, i == 74, "R5 start count");
    tick(gap, 1, "R5 enable stays");
    for (int c = 0; c < 4; c++) begin
      wr(c[1:0], "R6 write ignored when locked");
      chk(host_en && pad_sel, "R6 enable kept", host_en, 1);
    end
  endtask

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    for (int s = 0; s < 3; s++)
      for (int c = 0; c < 3; c++) begin
        do_reset();
        if (s == 1) wr(2'b00, "R2 power-off");
        if (s == 2) wr(2'b10, "R3 power-cycle");
        case (c)
          0: wr(2'b00, s == 1 ? "R8 same code off" : "R2 power-off");
          1: wr(2'b01, "R7 reserved ignored");
          default: wr(2'b10, s == 2 ? "R8 same code cycle" : "R3 power-cycle");
        endcase
        tick(1, 0, "R9 tick outside power-on has no effect");
      end
    do_reset();
    wr(2'b10, "R3 power-cycle");
    wr(2'b00, "R2 power-off");
    power_on_run(1);
    do_reset();
    power_on_run(2);
    do_reset();
    wr(2'b10, "R3 power-cycle");
    power_on_run(3);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule